// File: doc/BRIEF.md
# ADC Power and Mode Controller

This block holds the control state of a serial analog-to-digital converter. It decides whether the conversion core is enabled by merging a hardware power-down pin with already-decoded software power-up and power-down instructions. The two sources follow different rules. A high pin always wins. A software power-down always takes effect. A software power-down is undone either by a software power-up or by the pin going high and then low again.

When the core is switched off while a conversion is running, that conversion is aborted. The next result is then marked unreliable until a conversion completes with the core enabled. The block also tracks test mode against user mode and reports both the mode and the power state in a 16-bit status word. When the recovery sequence returns the device to user mode, it emits a one-cycle pulse so that the surrounding logic restores its default settings. The serial shift logic, the instruction decoder and the analog core sit outside this block.

Top module: `adc_pwr_mode_ctrl`

## Requirements
- R1: While `pd_pin` is high at a rising clock edge, `conv_en` is 0 and `status[0]` is 1 from that edge on.
- R2: A `cmd_pwr_up` pulse sampled while `pd_pin` is high leaves `conv_en` at 0 for as long as `pd_pin` stays high.
- R3: A `cmd_pwr_down` pulse powers the core down at the next edge whatever the level of `pd_pin`. When it arrives in the same cycle as `cmd_pwr_up` or a wake event, the power-down wins.
- R4: A software power-down is cleared by a `cmd_pwr_up` pulse, or by a falling edge of `pd_pin` (a low sample that follows a high sample). The core is enabled again once the pin is also low.
- R5: `conv_abort` is high for exactly one cycle after an edge at which `conv_en` changes from 1 to 0 while `busy` is high. It stays low in every other case.
- R6: `data_invalid` becomes 1 together with `conv_abort`. It returns to 0 after a `conv_done` pulse that is sampled while `conv_en` is 1. A `conv_done` pulse sampled while powered down has no effect.
- R7: A `cmd_test_mode` pulse sets `test_mode`. A `cmd_test_mode` pulse in the same cycle as `cmd_user_mode` keeps test mode set.
- R8: A `cmd_user_mode` pulse sampled while in test mode (without `cmd_test_mode`) does three things: it clears `test_mode`, it raises `cfg_default` for one cycle, and it clears any software power-down. In user mode the strobe has no effect.
- R9: `status[9]` equals the test mode, `status[0]` equals the power-down state, and all other status bits are 0.
- R10: Asserting `rst_n` low returns the block to user mode and powered up, with `conv_abort`, `data_invalid` and `cfg_default` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pd_pin | input | 1 | Hardware power-down pin, high = down |
| busy | input | 1 | Conversion in progress |
| conv_done | input | 1 | One-cycle pulse at the end of a conversion |
| cmd_pwr_up | input | 1 | Decoded software power-up pulse |
| cmd_pwr_down | input | 1 | Decoded software power-down pulse |
| cmd_test_mode | input | 1 | Decoded enter-test-mode pulse |
| cmd_user_mode | input | 1 | End of the return-to-user-mode sequence |
| conv_en | output | 1 | Conversion core enable |
| conv_abort | output | 1 | One-cycle abort of the running conversion |
| data_invalid | output | 1 | Next result is unreliable |
| test_mode | output | 1 | 1 = test mode, 0 = user mode |
| cfg_default | output | 1 | One-cycle pulse to restore default settings |
| status | output | 16 | Status word |

## Verification
The hardest state to reach is a software power-down that is still latched while the pin is high. From that state, only the falling edge of the pin may wake the core, and a power-up command given meanwhile must appear to do nothing. The random stimulus toggles the pin with low probability, so that it holds each level for several cycles while rare commands land inside those windows. Directed sequences then set up the abort-while-busy path, the stale-data flag and its clearing, and the test-mode recovery strobe on purpose.

// File: rtl/adc_pwr_mode_ctrl.sv
module adc_pwr_mode_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pd_pin,
  input  logic        busy,
  input  logic        conv_done,
  input  logic        cmd_pwr_up,
  input  logic        cmd_pwr_down,
  input  logic        cmd_test_mode,
  input  logic        cmd_user_mode,
  output logic        conv_en,
  output logic        conv_abort,
  output logic        data_invalid,
  output logic        test_mode,
  output logic        cfg_default,
  output logic [15:0] status
);

  logic pd_prev, sw_down, pwr_down;
  logic pd_fall, user_ret, sw_down_nx, pwr_down_nx, abort_nx;

  assign pd_fall     = pd_prev & ~pd_pin;
  assign user_ret    = cmd_user_mode & test_mode & ~cmd_test_mode;
  assign sw_down_nx  = cmd_pwr_down ? 1'b1 :
                       (cmd_pwr_up | pd_fall | user_ret) ? 1'b0 : sw_down;
  assign pwr_down_nx = pd_pin | sw_down_nx;
  assign abort_nx    = pwr_down_nx & ~pwr_down & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_prev      <= 1'b0;
      sw_down      <= 1'b0;
      pwr_down     <= 1'b0;
      conv_abort   <= 1'b0;
      data_invalid <= 1'b0;
      test_mode    <= 1'b0;
      cfg_default  <= 1'b0;
    end else begin
      pd_prev     <= pd_pin;
      sw_down     <= sw_down_nx;
      pwr_down    <= pwr_down_nx;
      conv_abort  <= abort_nx;
      cfg_default <= user_ret;
      if (abort_nx)
        data_invalid <= 1'b1;
      else if (conv_done && !pwr_down)
        data_invalid <= 1'b0;
      if (cmd_test_mode)
        test_mode <= 1'b1;
      else if (cmd_user_mode)
        test_mode <= 1'b0;
    end
  end

  assign conv_en = ~pwr_down;
  assign status  = {6'b0, test_mode, 8'b0, pwr_down};

  assert_pin_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pin |=> !conv_en);

  assert_sw_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pwr_down |=> (!conv_en && status[0]));

  assert_abort_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> (!conv_en && $past(conv_en) && $past(busy)));

  assert_abort_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> !conv_abort);

  assert_invalid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_invalid) |-> conv_abort);

  assert_test_enter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_test_mode |=> status[9]);

  assert_user_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_default |-> (!test_mode && $past(test_mode)));

endmodule

// File: tb/adc_pwr_mode_ctrl_test.sv
module adc_pwr_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst_n;
  logic pd_pin, busy, conv_done, cmd_pwr_up, cmd_pwr_down, cmd_test_mode, cmd_user_mode;
  logic conv_en, conv_abort, data_invalid, test_mode, cfg_default;
  logic [15:0] status;

  int total = 0;
  int bad = 0;

  logic m_pd_prev, m_sw, m_down, m_abort, m_inv, m_test, m_cfg;

  always #10 clk = ~clk;

  adc_pwr_mode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .busy(busy), .conv_done(conv_done),
    .cmd_pwr_up(cmd_pwr_up), .cmd_pwr_down(cmd_pwr_down),
    .cmd_test_mode(cmd_test_mode), .cmd_user_mode(cmd_user_mode),
    .conv_en(conv_en), .conv_abort(conv_abort), .data_invalid(data_invalid),
    .test_mode(test_mode), .cfg_default(cfg_default), .status(status)
  );

  function automatic logic [15:0] exp_status(input logic t, input logic d);
    exp_status = 16'd0;
    exp_status[9] = t;
    exp_status[0] = d;
  endfunction

  function automatic logic sw_next(input logic sw, input logic prev, input logic pd,
                                   input logic up, input logic dn, input logic ret);
    if (dn) sw_next = 1'b1;
    else if (up || (prev && !pd) || ret) sw_next = 1'b0;
    else sw_next = sw;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R1/R3/R4 conv_en", {15'd0, conv_en}, {15'd0, ~m_down});
    check("R5 conv_abort", {15'd0, conv_abort}, {15'd0, m_abort});
    check("R6 data_invalid", {15'd0, data_invalid}, {15'd0, m_inv});
    check("R7 test_mode", {15'd0, test_mode}, {15'd0, m_test});
    check("R8 cfg_default", {15'd0, cfg_default}, {15'd0, m_cfg});
    check("R9 status", status, exp_status(m_test, m_down));
  endtask

  task automatic model_reset();
    m_pd_prev = 0; m_sw = 0; m_down = 0; m_abort = 0; m_inv = 0; m_test = 0; m_cfg = 0;
  endtask

  task automatic step(input logic pd, input logic bz, input logic dn_done,
                      input logic up, input logic dn, input logic tm, input logic um);
    logic ret, swn, downn, abn;
    pd_pin = pd; busy = bz; conv_done = dn_done;
    cmd_pwr_up = up; cmd_pwr_down = dn; cmd_test_mode = tm; cmd_user_mode = um;
    @(posedge clk);
    ret   = um && m_test && !tm;
    swn   = sw_next(m_sw, m_pd_prev, pd, up, dn, ret);
    downn = pd | swn;
    abn   = downn && !m_down && bz;
    if (abn) m_inv = 1'b1;
    else if (dn_done && !m_down) m_inv = 1'b0;
    if (tm) m_test = 1'b1;
    else if (um) m_test = 1'b0;
    m_cfg = ret; m_abort = abn; m_sw = swn; m_down = downn; m_pd_prev = pd;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic pd_r;
    void'($urandom(1234));
    rst_n = 0;
    pd_pin = 0; busy = 0; conv_done = 0;
    cmd_pwr_up = 0; cmd_pwr_down = 0; cmd_test_mode = 0; cmd_user_mode = 0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R10 reset conv_en", {15'd0, conv_en}, 16'd1);
    check("R10 reset status", status, 16'd0);
    check("R10 reset flags", {13'd0, conv_abort, data_invalid, cfg_default}, 16'd0);
    rst_n = 1;

    // R1 and R2: pin high, power-up command ignored
    step(1,0,0,0,0,0,0);
    check("R1 conv_en low with pin high", {15'd0, conv_en}, 16'd0);
    step(1,0,0,1,0,0,0);
    check("R2 power-up ignored while pin high", {15'd0, conv_en}, 16'd0);
    step(0,0,0,0,0,0,0);
    check("R4 pin release wakes", {15'd0, conv_en}, 16'd1);

    // R3 and R5: software power-down while busy aborts
    step(0,1,0,0,1,0,0);
    check("R5 abort pulse", {15'd0, conv_abort}, 16'd1);
    check("R6 invalid set", {15'd0, data_invalid}, 16'd1);
    step(0,1,0,0,0,0,0);
    check("R5 abort one cycle", {15'd0, conv_abort}, 16'd0);
    step(0,0,1,0,0,0,0);
    check("R6 done while down ignored", {15'd0, data_invalid}, 16'd1);
    // R4: pin high then low clears software power-down
    step(1,0,0,0,0,0,0);
    step(0,0,0,0,0,0,0);
    check("R4 pin fall wakes after sw down", {15'd0, conv_en}, 16'd1);
    step(0,0,1,0,0,0,0);
    check("R6 invalid cleared by done", {15'd0, data_invalid}, 16'd0);
    // R3: down beats up
    step(0,0,0,1,1,0,0);
    check("R3 down wins over up", {15'd0, conv_en}, 16'd0);
    step(0,0,0,1,0,0,0);
    check("R4 sw up wakes", {15'd0, conv_en}, 16'd1);

    // R7, R8: test mode entry and return
    step(0,0,0,0,0,1,1);
    check("R7 test wins over user", {15'd0, test_mode}, 16'd1);
    step(0,0,0,0,1,0,0);
    step(0,0,0,0,0,0,1);
    check("R8 cfg_default pulse", {15'd0, cfg_default}, 16'd1);
    check("R8 sw down cleared on return", {15'd0, conv_en}, 16'd1);
    step(0,0,0,0,0,0,1);
    check("R8 no pulse in user mode", {15'd0, cfg_default}, 16'd0);

    // Random phase
    pd_r = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) pd_r = ~pd_r;
      step(pd_r, $urandom_range(0,1), $urandom_range(0,5) == 0,
           $urandom_range(0,7) == 0, $urandom_range(0,9) == 0,
           $urandom_range(0,29) == 0, $urandom_range(0,19) == 0);
    end

    // R10: reset mid-run
    step(0,0,0,0,0,1,0);
    rst_n = 0;
    model_reset();
    @(negedge clk);
    check("R10 reset returns to user mode", status, 16'd0);
    rst_n = 1;
    step(0,0,0,0,0,0,0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule